// File: doc/BRIEF.md
# Strobe-to-Clock Write Alignment Calibrator

This block runs once at start-up, and again on request, to find an output delay setting for the write strobe of each byte lane. With that setting the strobe's rising edge reaches the memory device together with the rising edge of the memory clock. On a daisy-chained clock route the clock reaches each device at a different time, and the offset can approach 0.8 of a clock period. For that reason each lane is searched on its own.

The search runs as a closed loop. The block drives one strobe pulse, waits a fixed settling time, and then reads one feedback bit per lane. That bit is the memory clock level that the device latched on the strobe edge. The block then moves the delay tap of every lane that is still searching up by one. A lane stops at the first tap where the feedback reads 1 after a tap where it read 0. A lane that runs out of taps without seeing that change is marked failed. The mode-register sequence that puts the device in this feedback mode is outside the block, and so is the physical delay cell.

Top module: `strobe_align_cal`

## Requirements
- R1: During and after reset, `done_o`, `pulse_o`, every `locked_o` and `failed_o` bit and every tap field read 0.
- R2: A `start_i` high at a clock edge while idle or finished starts a calibration. At the next edge every tap becomes 0, all status bits and `done_o` clear, and `pulse_o` is high for the first probe.
- R3: Each probe is one cycle with `pulse_o` high, then 8 cycles with it low, then one sample cycle at whose closing edge `fb_i` is taken. Pulses are therefore one cycle wide and 10 cycles apart.
- R4: A searching lane that has already read feedback 0 locks at the first probe that reads 1. Its tap stays at the tap of that probe, and `locked_o` for the lane goes high.
- R5: Feedback reads of 1 that come before any read of 0 do not lock a lane. The lane keeps stepping until it has seen 0.
- R6: Each probe that does not finish a lane raises that lane's tap by exactly one.
- R7: A lane whose probe at the top tap (63 for 6-bit taps) does not lock it is marked failed, and its tap stays at 63. A 0-then-1 change that completes exactly at tap 63 locks the lane.
- R8: Lanes are independent. A lane that has locked or failed keeps its tap and status while other lanes go on searching. Its later feedback has no effect.
- R9: `done_o` rises at the sample edge of the probe that finishes the last lane, which is 10×P cycles after the start edge for P probes. It stays high, with no further pulses, until the next start.
- R10: `start_i` is ignored while a calibration is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a calibration (taken while idle or finished) |
| fb_i | input | LANES | Per-lane latched memory clock level |
| pulse_o | output | 1 | One-cycle request to the strobe driver |
| tap_o | output | LANES×TAP_W | Per-lane strobe delay tap, lane 0 in the low bits |
| locked_o | output | LANES | Lane found its rising transition |
| failed_o | output | LANES | Lane ran out of taps |
| done_o | output | 1 | All lanes locked or failed |

## Verification
Two things can fall on the same sample edge. The probe that finishes the last lane also ends the whole run. At that edge one lane's lock or fail decision, together with the other lanes' holds, must raise `done_o` with no extra pulse after it. The bench provokes this by giving several lanes the same finishing probe, and by placing finishes at tap 63 so that a lock and a fail can land together. It judges the result by the cycle at which `done_o` rises and by the pulse count, both checked against a probe count computed from the lane models. A start raised mid-run, in the same window as ongoing probes, must leave both unchanged.

// File: rtl/wl_cal_pkg.sv
package wl_cal_pkg;

    parameter int WL_SETTLE_DEF = 8;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_SEEK_LOW,
        LN_SEEK_RISE,
        LN_LOCKED,
        LN_FAILED
    } lane_st_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PULSE,
        SQ_WAIT,
        SQ_SAMPLE,
        SQ_DONE
    } seq_st_e;

    typedef struct packed {
        lane_st_e st;
        logic     bump;
    } lane_step_t;

    function automatic logic lane_busy(lane_st_e s);
        return (s == LN_SEEK_LOW) || (s == LN_SEEK_RISE);
    endfunction

    function automatic logic lane_final(lane_st_e s);
        return (s == LN_LOCKED) || (s == LN_FAILED);
    endfunction

    // One probe outcome for a lane: new state and whether the tap advances.
    function automatic lane_step_t lane_step(lane_st_e cur, logic fb, logic at_max);
        lane_step_t r;
        r.st   = cur;
        r.bump = 1'b0;
        case (cur)
            LN_SEEK_LOW:  if (!fb) r.st = LN_SEEK_RISE;
            LN_SEEK_RISE: if (fb)  r.st = LN_LOCKED;
            default:      r.st = cur;
        endcase
        if (lane_busy(cur) && lane_busy(r.st)) begin
            if (at_max) r.st   = LN_FAILED;
            else        r.bump = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/wl_probe_seq.sv
module wl_probe_seq
    import wl_cal_pkg::*;
#(
    parameter int SETTLE = WL_SETTLE_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic all_fin_nxt_i,
    output logic launch_o,
    output logic pulse_o,
    output logic sample_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(SETTLE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

    seq_st_e          st;
    logic [CNT_W-1:0] cnt;

    assign launch_o = start_i && ((st == SQ_IDLE) || (st == SQ_DONE));
    assign pulse_o  = (st == SQ_PULSE);
    assign sample_o = (st == SQ_SAMPLE);
    assign done_o   = (st == SQ_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else if (launch_o) begin
            st  <= SQ_PULSE;
            cnt <= '0;
        end else begin
            case (st)
                SQ_PULSE: begin
                    st  <= SQ_WAIT;
                    cnt <= '0;
                end
                SQ_WAIT: begin
                    if (cnt == CNT_LAST) st <= SQ_SAMPLE;
                    else                 cnt <= cnt + 1'b1;
                end
                SQ_SAMPLE: st <= all_fin_nxt_i ? SQ_DONE : SQ_PULSE;
                default:   st <= st;
            endcase
        end
    end
endmodule

// File: rtl/wl_lane.sv
module wl_lane
    import wl_cal_pkg::*;
#(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             sample_i,
    input  logic             fb_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             locked_o,
    output logic             failed_o,
    output logic             fin_nxt_o
);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    lane_st_e   st;
    lane_step_t step;

    always_comb begin
        step      = lane_step(st, fb_i, tap_o == TAP_MAX);
        fin_nxt_o = sample_i ? lane_final(step.st) : lane_final(st);
    end

    assign locked_o = (st == LN_LOCKED);
    assign failed_o = (st == LN_FAILED);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= LN_IDLE;
            tap_o <= '0;
        end else if (clear_i) begin
            st    <= LN_SEEK_LOW;
            tap_o <= '0;
        end else if (sample_i) begin
            st <= step.st;
            if (step.bump) tap_o <= tap_o + 1'b1;
        end
    end
endmodule

// File: rtl/strobe_align_cal.sv
module strobe_align_cal
    import wl_cal_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int TAP_W  = 6,
    parameter int SETTLE = WL_SETTLE_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [LANES-1:0]       fb_i,
    output logic                   pulse_o,
    output logic [LANES*TAP_W-1:0] tap_o,
    output logic [LANES-1:0]       locked_o,
    output logic [LANES-1:0]       failed_o,
    output logic                   done_o
);
    logic             launch;
    logic             sample;
    logic [LANES-1:0] fin_nxt;

    wl_probe_seq #(.SETTLE(SETTLE)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .all_fin_nxt_i (&fin_nxt),
        .launch_o      (launch),
        .pulse_o       (pulse_o),
        .sample_o      (sample),
        .done_o        (done_o)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        wl_lane #(.TAP_W(TAP_W)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .clear_i   (launch),
            .sample_i  (sample),
            .fb_i      (fb_i[i]),
            .tap_o     (tap_o[i*TAP_W +: TAP_W]),
            .locked_o  (locked_o[i]),
            .failed_o  (failed_o[i]),
            .fin_nxt_o (fin_nxt[i])
        );
    end
endmodule

// File: rtl/wl_cal_checker.sv
module wl_cal_checker #(
    parameter int LANES = 4,
    parameter int TAP_W = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start_i,
    input logic                   pulse_o,
    input logic [LANES*TAP_W-1:0] tap_o,
    input logic [LANES-1:0]       locked_o,
    input logic [LANES-1:0]       failed_o,
    input logic                   done_o
);
    localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    p_done_all_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((locked_o | failed_o) == {LANES{1'b1}}));

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !pulse_o);

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        p_lock_excl_r4: assert property (@(posedge clk) disable iff (rst)
            !(locked_o[i] && failed_o[i]));

        p_fail_tap_r7: assert property (@(posedge clk) disable iff (rst)
            failed_o[i] |-> (tap_o[i*TAP_W +: TAP_W] == TOP));

        p_hold_tap_r8: assert property (@(posedge clk) disable iff (rst)
            ((locked_o[i] || failed_o[i]) && !start_i) |=> $stable(tap_o[i*TAP_W +: TAP_W]));

        p_tap_step_r6: assert property (@(posedge clk) disable iff (rst)
            (tap_o[i*TAP_W +: TAP_W] != $past(tap_o[i*TAP_W +: TAP_W])) |->
            ((tap_o[i*TAP_W +: TAP_W] == $past(tap_o[i*TAP_W +: TAP_W]) + 1'b1) ||
             (tap_o[i*TAP_W +: TAP_W] == '0)));
    end
endmodule

bind strobe_align_cal wl_cal_checker #(.LANES(LANES), .TAP_W(TAP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .pulse_o  (pulse_o),
    .tap_o    (tap_o),
    .locked_o (locked_o),
    .failed_o (failed_o),
    .done_o   (done_o)
);

// File: tb/tb_strobe_align_cal.sv
module tb_strobe_align_cal;
    localparam int LANES = 4;
    localparam int TAP_W = 6;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   start_i = 1'b0;
    logic [LANES-1:0]       fb_i;
    logic                   pulse_o;
    logic [LANES*TAP_W-1:0] tap_o;
    logic [LANES-1:0]       locked_o;
    logic [LANES-1:0]       failed_o;
    logic                   done_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    // Device model per lane: feedback 1 below hi_end and at or above rise_at.
    int hi_end  [LANES];
    int rise_at [LANES];

    strobe_align_cal #(.LANES(LANES), .TAP_W(TAP_W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .fb_i(fb_i), .pulse_o(pulse_o),
        .tap_o(tap_o), .locked_o(locked_o), .failed_o(failed_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            fb_i[l] = model(l, int'(tap_o[l*TAP_W +: TAP_W]));
        end
    end

    function automatic logic model(int l, int t);
        return (t < hi_end[l]) || (t >= rise_at[l]);
    endfunction

    // Expected result per the requirements: lock tap, or 63 with fail.
    function automatic void expect_lane(int l, output bit lk, output int tap, output int probes);
        bit seen0 = 1'b0;
        lk = 1'b0; tap = 63; probes = 64;
        for (int t = 0; t < 64; t++) begin
            bit f = model(l, t);
            if (seen0 && f) begin
                lk = 1'b1; tap = t; probes = t + 1;
                return;
            end
            if (!f) seen0 = 1'b1;
        end
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_cal(int mid_start);
        bit lk_e [LANES];
        int tap_e [LANES];
        int pr, p_max = 0, pulses = 0, n = 1, bad_pulse = 0, hold_bad = 0;
        logic [LANES*TAP_W-1:0] prev_tap;
        logic [LANES-1:0] prev_fin;
        for (int l = 0; l < LANES; l++) begin
            expect_lane(l, lk_e[l], tap_e[l], pr);
            if (pr > p_max) p_max = pr;
        end
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        // R2: cleared state and first pulse, one edge after start
        check(pulse_o === 1'b1 && done_o === 1'b0 && locked_o === '0 && failed_o === '0 &&
              tap_o === '0, "R2", "cleared start", int'(pulse_o), 1);
        prev_tap = tap_o; prev_fin = locked_o | failed_o;
        while (done_o !== 1'b1 && n < 1000) begin
            if (pulse_o === 1'b1) begin
                pulses++;
                if ((n - 1) % 10 != 0) bad_pulse++;
            end
            if (mid_start > 0 && n == mid_start) start_i = 1'b1;
            if (mid_start > 0 && n == mid_start + 1) start_i = 1'b0;
            @(negedge clk); n++;
            for (int l = 0; l < LANES; l++)
                if (prev_fin[l] && tap_o[l*TAP_W +: TAP_W] !== prev_tap[l*TAP_W +: TAP_W]) hold_bad++;
            prev_tap = tap_o; prev_fin = locked_o | failed_o;
        end
        start_i = 1'b0;
        check(n == 10 * p_max + 1, "R9", "done latency", n, 10 * p_max + 1);
        check(pulses == p_max && bad_pulse == 0, "R3", "pulse count/spacing", pulses, p_max);
        check(hold_bad == 0, "R8", "finished lane tap hold", hold_bad, 0);
        for (int l = 0; l < LANES; l++) begin
            int t = int'(tap_o[l*TAP_W +: TAP_W]);
            check(locked_o[l] === lk_e[l] && failed_o[l] === !lk_e[l],
                  lk_e[l] ? "R4" : "R7", "lane status", int'(locked_o[l]), int'(lk_e[l]));
            check(t == tap_e[l], lk_e[l] ? "R6" : "R7", "lane tap", t, tap_e[l]);
        end
        pulses = 0;
        repeat (20) begin
            @(negedge clk);
            if (pulse_o === 1'b1) pulses++;
        end
        check(done_o === 1'b1 && pulses == 0, "R9", "done held quiet", pulses, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int l = 0; l < LANES; l++) begin hi_end[l] = 0; rise_at[l] = 70; end
        repeat (4) @(negedge clk);
        // R1: reset values
        check(done_o === 1'b0 && pulse_o === 1'b0 && locked_o === '0 && failed_o === '0 &&
              tap_o === '0, "R1", "reset state", int'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o === 1'b0 && pulse_o === 1'b0, "R1", "idle after reset", int'(pulse_o), 0);

        // Directed: always-1 fail, lock at 63, no rise fail, high start then rise (R5)
        hi_end[0] = 0;  rise_at[0] = 0;
        hi_end[1] = 0;  rise_at[1] = 63;
        hi_end[2] = 0;  rise_at[2] = 64;
        hi_end[3] = 5;  rise_at[3] = 20;
        run_cal(0);

        // Directed: same finishing probe on all lanes, plus R10 start during run
        for (int l = 0; l < LANES; l++) begin hi_end[l] = 3; rise_at[l] = 12; end
        run_cal(25);

        // Directed R5: high region that merges with rise fails; early lock at 1
        hi_end[0] = 10; rise_at[0] = 10;
        hi_end[1] = 0;  rise_at[1] = 1;
        hi_end[2] = 1;  rise_at[2] = 2;
        hi_end[3] = 40; rise_at[3] = 63;
        run_cal(0);

        // Random lane models
        for (int k = 0; k < 12; k++) begin
            for (int l = 0; l < LANES; l++) begin
                hi_end[l]  = ($urandom % 3 == 0) ? int'($urandom % 20) : 0;
                rise_at[l] = int'($urandom % 72);
            end
            run_cal((k % 3 == 0) ? 40 : 0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule